// File: doc/BRIEF.md
# Fine-Grained Instruction Trap Checker

This block holds a 64-bit hypervisor trap-control register and decides, for each instruction the pipeline reports as executed, whether that instruction must be trapped to the hypervisor exception level (EL2). The decision depends on several inputs:

- the current exception level and its execution state;
- whether EL1 runs in 32-bit state;
- whether EL2 is present and enabled;
- whether EL3 is present, and the state of its fine-grained-trap enable;
- the host-mode pair {E2H,TGE};
- the nXS-trap control;
- whether a higher-priority exception is pending.

When the instruction traps, the block also reports the 6-bit exception-class syndrome.

The pipeline encodes each instruction as a 6-bit class code. The code is the bit position in the control register that governs the instruction, so decoding the code amounts to selecting one register bit. Bit 53 is SVC at EL1. Bit 52 is SVC at EL0. Bit 51 is exception return and its authenticated forms. Bits 50..48 are the prediction-restriction operations. Bits 47..18 are TLB maintenance. Bits 17..12 are address translation. Bit 54 and bits 11..0 are cache maintenance. Of the cache-maintenance bits, bit 54 and bits 11..8 also cover EL0; bits 7..0 cover EL1 only. A separate flag marks the nXS form of a TLB operation.

Optional features are chosen at elaboration by parameters. A control bit whose feature is absent has no storage and reads as zero. Software writes the register through a simple write strobe and reads it back on a combinational read port. The trap strobe and the syndrome are registered.

Top module: `fgt_trap_unit`

## Requirements
- R1: After reset the control register reads 0, and both `trap_o` and `syndrome_o` are 0.
- R2: Bits 63..55 always read 0. A bit whose optional feature is absent also reads 0, whatever was written, and never traps. The features and their bits are:
  - prediction restriction: bits 50..48;
  - range TLB operations: bits 41..34 and 27..24;
  - outer-shareable TLB operations: bits 27..18;
  - second privileged-access-never: bits 17..16;
  - clean-to-persistence: bit 9.
  With the default parameters, writing all ones reads back 0x007FFFFFF003FDFF.
- R3: A set bit traps only under both of these conditions:
  - `el2_enabled` is 1;
  - `el3_present` is 0, or `el3_fgt_en` is 1.
  Instructions executed at EL2 or EL3 (`cur_el` 2 or 3) never trap.
- R4: Class 53 traps SVC at EL1 in 64-bit state with syndrome 0x15. It does not trap at EL0.
- R5: Class 52 traps SVC at EL0. The syndrome is 0x15 in 64-bit state and 0x11 in 32-bit state. There is no trap when `el1_aa32` is 1.
- R6: Class 51 traps exception return at EL1 in 64-bit state with syndrome 0x1A. There is no trap at EL0.
- R7: Classes 50..48 trap with syndrome 0x18 at EL1 or EL0 in 64-bit state, and with syndrome 0x03 at EL0 in 32-bit state. They require `el1_aa32` to be 0.
- R8: The EL0-scope classes (54, 52, 50..48 and 11..8) never trap when `host_e2h` and `host_tge` are both 1. This holds even at EL1. All other classes ignore the host-mode pair.
- R9: TLB classes (47..18), address-translation classes (17..12) and EL1-only cache classes (7..0) trap only at EL1 in 64-bit state, with syndrome 0x18. The EL0-scope cache classes (54 and 11..8) also trap at EL0 in 64-bit state.
- R10: For a TLB class with `insn_nxs` at 1, the trap also requires the nXS feature to be present and `nxs_trap_ctl` to be 0. The plain form ignores `nxs_trap_ctl`.
- R11: A pending higher-priority exception (`hi_prio_pending` at 1) suppresses the trap.
- R12: `trap_o` and `syndrome_o` reflect the instruction presented with `insn_valid` one clock edge earlier. Both are 0 after a cycle without `insn_valid`. The syndrome is 0 whenever there is no trap.
- R13: An instruction presented in the same cycle as a register write is judged against the register value held before that write.
- R14: Class codes 55..63 never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (warm reset into EL2) |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Control register read value, with read-as-zero bits masked |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_class | input | 6 | Class code: position of the governing control bit |
| insn_nxs | input | 1 | The TLB operation is the nXS form |
| cur_el | input | 2 | Current exception level (0 to 3) |
| cur_aa32 | input | 1 | The instruction executes in 32-bit state |
| el1_aa32 | input | 1 | EL1 runs in 32-bit state |
| el2_enabled | input | 1 | EL2 is implemented and enabled in the current security state |
| el3_present | input | 1 | EL3 is implemented |
| el3_fgt_en | input | 1 | EL3 fine-grained-trap enable |
| host_e2h | input | 1 | Host-mode E2H bit |
| host_tge | input | 1 | Host-mode TGE bit |
| nxs_trap_ctl | input | 1 | When 1, nXS TLB forms are not trapped |
| hi_prio_pending | input | 1 | The instruction raises a higher-priority exception |
| trap_o | output | 1 | Trap the instruction to EL2 |
| syndrome_o | output | 6 | Exception-class syndrome (0 when there is no trap) |

## Verification
Every trap decision and syndrome is due exactly one clock edge after the cycle in which `insn_valid` is high. Register read-back is due at the first sample after the write edge. The driver presents each instruction at a falling edge and queues the expected pair. The monitor pops and compares at the next falling edge, once the registering edge has passed. The idle-zero and same-cycle-write cases are sampled at the falling edge that follows their own registering edge.

// File: rtl/fgt_pkg.sv
// Package: shared types, constants and mask builders for the fine-grained
// instruction trap checker. Assumes class code == governing control bit.
package fgt_pkg;

    localparam int CTL_W   = 64;
    localparam int USED_W  = 55;
    localparam int CODE_W  = 6;
    localparam int EC_W    = 6;

    localparam logic [EC_W-1:0] EC_NONE   = 6'h00;
    localparam logic [EC_W-1:0] EC_SVC64  = 6'h15;
    localparam logic [EC_W-1:0] EC_SVC32  = 6'h11;
    localparam logic [EC_W-1:0] EC_ERET   = 6'h1A;
    localparam logic [EC_W-1:0] EC_SYSREG = 6'h18;
    localparam logic [EC_W-1:0] EC_CP32   = 6'h03;

    typedef enum logic [2:0] {
        K_NONE,
        K_SVC_EL1,
        K_SVC_EL0,
        K_ERET,
        K_PRED,
        K_TLB,
        K_ADDR,
        K_CMO
    } op_kind_t;

    // Map a class code to the kind of operation it governs.
    function automatic op_kind_t kind_of(input logic [CODE_W-1:0] code);
        int unsigned c;
        c = int'(code);
        if (c == 54)                 return K_CMO;
        else if (c == 53)            return K_SVC_EL1;
        else if (c == 52)            return K_SVC_EL0;
        else if (c == 51)            return K_ERET;
        else if (c >= 48 && c <= 50) return K_PRED;
        else if (c >= 18 && c <= 47) return K_TLB;
        else if (c >= 12 && c <= 17) return K_ADDR;
        else if (c <= 11)            return K_CMO;
        return K_NONE;
    endfunction

    // Bits whose operations are also executable at EL0 (host-mode gated).
    function automatic logic [CTL_W-1:0] el0_scope_mask();
        logic [CTL_W-1:0] m;
        m = '0;
        m[54] = 1'b1;
        m[52] = 1'b1;
        for (int i = 48; i <= 50; i++) m[i] = 1'b1;
        for (int i = 8; i <= 11; i++)  m[i] = 1'b1;
        return m;
    endfunction

    // Bits that hold storage for the given feature set.
    function automatic logic [CTL_W-1:0] writable_mask(
        input bit specres, input bit range_tlb, input bit os_tlb,
        input bit pan2, input bit dpb2);
        logic [CTL_W-1:0] m;
        m = '0;
        for (int i = 0; i < USED_W; i++) m[i] = 1'b1;
        if (!specres)   for (int i = 48; i <= 50; i++) m[i] = 1'b0;
        if (!range_tlb) begin
            for (int i = 34; i <= 41; i++) m[i] = 1'b0;
            for (int i = 24; i <= 27; i++) m[i] = 1'b0;
        end
        if (!os_tlb)    for (int i = 18; i <= 27; i++) m[i] = 1'b0;
        if (!pan2)      for (int i = 16; i <= 17; i++) m[i] = 1'b0;
        if (!dpb2)      m[9] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/fgt_ctl_reg.sv
// Control register: one flop per writable bit, constant zero elsewhere.
// Assumes WMASK is an elaboration constant; absent bits cost no storage.
module fgt_ctl_reg
    import fgt_pkg::*;
#(
    parameter logic [CTL_W-1:0] WMASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q
);

    for (genvar i = 0; i < CTL_W; i++) begin : g_bit
        if (WMASK[i]) begin : g_store
            // Hold one writable control bit, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)     ctl_q[i] <= 1'b0;
                else if (wr_en) ctl_q[i] <= wr_data[i];
            end
        end else begin : g_raz
            assign ctl_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/fgt_gate.sv
// Trap gate: combines the selected control bit with the level, state,
// host-mode, nXS, EL2/EL3 enables and priority to give a trap decision.
// Purely combinational; assumes ctl_q already has read-as-zero bits cleared.
module fgt_gate
    import fgt_pkg::*;
#(
    parameter bit HAS_XS = 1'b1
) (
    input  logic [CTL_W-1:0]  ctl_q,
    input  logic [CODE_W-1:0] insn_class,
    input  logic              insn_nxs,
    input  logic [1:0]        cur_el,
    input  logic              cur_aa32,
    input  logic              el1_aa32,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              el3_fgt_en,
    input  logic              host_e2h,
    input  logic              host_tge,
    input  logic              nxs_trap_ctl,
    input  logic              hi_prio_pending,
    output op_kind_t          kind,
    output logic              trap_now
);

    localparam logic [CTL_W-1:0] EL0_MASK = el0_scope_mask();

    logic base_ok, host_ok, at_el0, at_el1, scope_el0, bit_set, nxs_ok, allowed;

    // Decode the class and evaluate the common enables.
    always_comb begin
        kind      = kind_of(insn_class);
        bit_set   = ctl_q[insn_class];
        scope_el0 = EL0_MASK[insn_class];
        base_ok   = el2_enabled && (!el3_present || el3_fgt_en);
        host_ok   = !(host_e2h && host_tge);
        at_el0    = (cur_el == 2'd0);
        at_el1    = (cur_el == 2'd1);
        nxs_ok    = !insn_nxs || (HAS_XS && !nxs_trap_ctl);
    end

    // Per-kind condition on level, execution state and host mode.
    always_comb begin
        unique case (kind)
            K_SVC_EL1: allowed = at_el1 && !cur_aa32;
            K_SVC_EL0: allowed = at_el0 && !el1_aa32 && host_ok;
            K_ERET:    allowed = at_el1 && !cur_aa32;
            K_PRED:    allowed = host_ok && !el1_aa32 &&
                                 ((at_el1 && !cur_aa32) || at_el0);
            K_TLB:     allowed = at_el1 && !cur_aa32 && nxs_ok;
            K_ADDR:    allowed = at_el1 && !cur_aa32;
            K_CMO:     allowed = scope_el0 ?
                                 (host_ok && !cur_aa32 && (at_el0 || at_el1)) :
                                 (at_el1 && !cur_aa32);
            default:   allowed = 1'b0;
        endcase
    end

    // Final decision, suppressed by a higher-priority exception.
    always_comb trap_now = bit_set && base_ok && allowed && !hi_prio_pending;

endmodule

// File: rtl/fgt_ec_sel.sv
// Syndrome selector: picks the exception-class code from the operation
// kind and the execution state. Assumes it is used only when trapping.
module fgt_ec_sel
    import fgt_pkg::*;
(
    input  op_kind_t        kind,
    input  logic            cur_aa32,
    output logic [EC_W-1:0] ec
);

    // Choose the exception class for the trapped operation.
    always_comb begin
        unique case (kind)
            K_SVC_EL1: ec = EC_SVC64;
            K_SVC_EL0: ec = cur_aa32 ? EC_SVC32 : EC_SVC64;
            K_ERET:    ec = EC_ERET;
            K_PRED:    ec = cur_aa32 ? EC_CP32 : EC_SYSREG;
            K_TLB,
            K_ADDR,
            K_CMO:     ec = EC_SYSREG;
            default:   ec = EC_NONE;
        endcase
    end

endmodule

// File: rtl/fgt_trap_unit.sv
// Top: hypervisor fine-grained instruction trap checker. Holds the control
// register, judges each valid instruction and registers trap and syndrome.
// Assumes one instruction per cycle and feature presence fixed at build.
module fgt_trap_unit
    import fgt_pkg::*;
#(
    parameter bit HAS_SPECRES = 1'b1,
    parameter bit HAS_RANGE   = 1'b1,
    parameter bit HAS_OS      = 1'b0,
    parameter bit HAS_PAN2    = 1'b1,
    parameter bit HAS_DPB2    = 1'b0,
    parameter bit HAS_XS      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    output logic [63:0]       rd_data,
    input  logic              insn_valid,
    input  logic [5:0]        insn_class,
    input  logic              insn_nxs,
    input  logic [1:0]        cur_el,
    input  logic              cur_aa32,
    input  logic              el1_aa32,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              el3_fgt_en,
    input  logic              host_e2h,
    input  logic              host_tge,
    input  logic              nxs_trap_ctl,
    input  logic              hi_prio_pending,
    output logic              trap_o,
    output logic [5:0]        syndrome_o
);

    localparam logic [CTL_W-1:0] WMASK =
        writable_mask(HAS_SPECRES, HAS_RANGE, HAS_OS, HAS_PAN2, HAS_DPB2);

    logic [CTL_W-1:0] ctl_q;
    op_kind_t         kind;
    logic             trap_now;
    logic [EC_W-1:0]  ec;
    logic             trap_q;
    logic [EC_W-1:0]  syn_q;

    fgt_ctl_reg #(.WMASK(WMASK)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data & WMASK),
        .ctl_q   (ctl_q)
    );

    fgt_gate #(.HAS_XS(HAS_XS)) u_gate (
        .ctl_q           (ctl_q),
        .insn_class      (insn_class),
        .insn_nxs        (insn_nxs),
        .cur_el          (cur_el),
        .cur_aa32        (cur_aa32),
        .el1_aa32        (el1_aa32),
        .el2_enabled     (el2_enabled),
        .el3_present     (el3_present),
        .el3_fgt_en      (el3_fgt_en),
        .host_e2h        (host_e2h),
        .host_tge        (host_tge),
        .nxs_trap_ctl    (nxs_trap_ctl),
        .hi_prio_pending (hi_prio_pending),
        .kind            (kind),
        .trap_now        (trap_now)
    );

    fgt_ec_sel u_ec (
        .kind     (kind),
        .cur_aa32 (cur_aa32),
        .ec       (ec)
    );

    // Register the decision for the instruction presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
            syn_q  <= EC_NONE;
        end else begin
            trap_q <= insn_valid && trap_now;
            syn_q  <= (insn_valid && trap_now) ? ec : EC_NONE;
        end
    end

    assign rd_data    = ctl_q & WMASK;
    assign trap_o     = trap_q;
    assign syndrome_o = syn_q;

endmodule

// File: rtl/fgt_trap_unit_chk.sv
// Checker: temporal properties of the trap checker at its ports.
// Assumes synchronous active-low reset; bound to every fgt_trap_unit.
module fgt_trap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] rd_data,
    input logic        insn_valid,
    input logic [1:0]  cur_el,
    input logic        el2_enabled,
    input logic        el3_present,
    input logic        el3_fgt_en,
    input logic        hi_prio_pending,
    input logic        trap_o,
    input logic [5:0]  syndrome_o
);

    p_reserved_raz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[63:55] == 9'd0);

    p_base_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !(el2_enabled && (!el3_present || el3_fgt_en))) |=> !trap_o);

    p_high_el_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cur_el[1]) |=> !trap_o);

    p_eret_el1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cur_el != 2'd1) |=> syndrome_o != 6'h1A);

    p_hi_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && hi_prio_pending) |=> !trap_o);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> (!trap_o && syndrome_o == 6'd0));

    p_syn_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> syndrome_o == 6'd0);

    p_syn_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (syndrome_o == 6'h15 || syndrome_o == 6'h11 ||
                    syndrome_o == 6'h1A || syndrome_o == 6'h18 ||
                    syndrome_o == 6'h03));

endmodule

bind fgt_trap_unit fgt_trap_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_data         (rd_data),
    .insn_valid      (insn_valid),
    .cur_el          (cur_el),
    .el2_enabled     (el2_enabled),
    .el3_present     (el3_present),
    .el3_fgt_en      (el3_fgt_en),
    .hi_prio_pending (hi_prio_pending),
    .trap_o          (trap_o),
    .syndrome_o      (syndrome_o)
);

// File: tb/sim_fgt_trap_unit.sv
// Scoreboard bench for fgt_trap_unit with default parameters.
module sim_fgt_trap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        insn_valid = 1'b0;
    logic [5:0]  insn_class = '0;
    logic        insn_nxs = 1'b0;
    logic [1:0]  cur_el = 2'd1;
    logic        cur_aa32 = 1'b0;
    logic        el1_aa32 = 1'b0;
    logic        el2_enabled = 1'b1;
    logic        el3_present = 1'b1;
    logic        el3_fgt_en = 1'b1;
    logic        host_e2h = 1'b0;
    logic        host_tge = 1'b0;
    logic        nxs_trap_ctl = 1'b0;
    logic        hi_prio_pending = 1'b0;
    logic        trap_o;
    logic [5:0]  syndrome_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       trap;
        logic [5:0] syn;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic issued_d = 1'b0;

    always #5 clk = ~clk;

    fgt_trap_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .insn_valid(insn_valid), .insn_class(insn_class),
        .insn_nxs(insn_nxs), .cur_el(cur_el), .cur_aa32(cur_aa32),
        .el1_aa32(el1_aa32), .el2_enabled(el2_enabled),
        .el3_present(el3_present), .el3_fgt_en(el3_fgt_en),
        .host_e2h(host_e2h), .host_tge(host_tge), .nxs_trap_ctl(nxs_trap_ctl),
        .hi_prio_pending(hi_prio_pending), .trap_o(trap_o),
        .syndrome_o(syndrome_o)
    );

    task automatic check(input bit ok, input string tag, input string detail);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    // Monitor: an instruction sampled at a rising edge is judged at the next falling edge.
    always @(posedge clk) issued_d <= insn_valid;

    always @(negedge clk) begin
        if (issued_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(trap_o === e.trap && syndrome_o === e.syn, e.tag,
                  $sformatf("trap=%0b syn=0x%02h expected trap=%0b syn=0x%02h",
                            trap_o, syndrome_o, e.trap, e.syn));
        end
    end

    // Driver: present one instruction for one cycle and queue its expected result.
    task automatic issue(input int cls, input int el, input bit aa32, input bit nxs,
                         input bit et, input logic [5:0] es, input string tag);
        @(negedge clk);
        insn_class = 6'(cls);
        cur_el     = 2'(el);
        cur_aa32   = aa32;
        insn_nxs   = nxs;
        insn_valid = 1'b1;
        exp_q.push_back('{et, es, tag});
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic write_ctl(input logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data === 64'd0 && trap_o === 1'b0 && syndrome_o === 6'd0, "R1",
              $sformatf("rd=0x%016h trap=%0b syn=0x%02h expected 0/0/0", rd_data, trap_o, syndrome_o));
        rst_n = 1'b1;
        @(negedge clk);

        // R2: read-as-zero masking (defaults: outer-shareable and DPB2 absent)
        write_ctl('1);
        check(rd_data === 64'h007F_FFFF_F003_FDFF, "R2",
              $sformatf("rd=0x%016h expected 0x007ffffff003fdff", rd_data));
        issue(20, 1, 0, 0, 1'b0, 6'h00, "R2 absent outer-shareable bit");
        issue(9, 1, 0, 0, 1'b0, 6'h00, "R2 absent DPB2 bit");

        // R4 / R5 / R6
        issue(53, 1, 0, 0, 1'b1, 6'h15, "R4 SVC at EL1");
        issue(53, 0, 0, 0, 1'b0, 6'h00, "R4 SVC bit at EL0");
        issue(52, 0, 0, 0, 1'b1, 6'h15, "R5 SVC EL0 64-bit");
        issue(52, 0, 1, 0, 1'b1, 6'h11, "R5 SVC EL0 32-bit");
        el1_aa32 = 1'b1;
        issue(52, 0, 1, 0, 1'b0, 6'h00, "R5 EL1 in 32-bit state");
        issue(49, 0, 1, 0, 1'b0, 6'h00, "R7 EL1 in 32-bit state");
        el1_aa32 = 1'b0;
        issue(51, 1, 0, 0, 1'b1, 6'h1A, "R6 ERET at EL1");
        issue(51, 0, 0, 0, 1'b0, 6'h00, "R6 ERET at EL0");

        // R7 prediction restriction
        issue(49, 1, 0, 0, 1'b1, 6'h18, "R7 EL1 64-bit");
        issue(50, 0, 1, 0, 1'b1, 6'h03, "R7 EL0 32-bit");
        issue(48, 0, 0, 0, 1'b1, 6'h18, "R7 EL0 64-bit");

        // R8 host-mode gate
        host_e2h = 1'b1; host_tge = 1'b1;
        issue(52, 0, 0, 0, 1'b0, 6'h00, "R8 SVC EL0 host mode");
        issue(10, 1, 0, 0, 1'b0, 6'h00, "R8 EL0-scope cache op at EL1 host mode");
        issue(40, 1, 0, 0, 1'b1, 6'h18, "R8 TLB ignores host mode");
        host_tge = 1'b0;
        issue(10, 0, 0, 0, 1'b1, 6'h18, "R8 E2H alone does not gate");
        host_e2h = 1'b0;

        // R9 level and state scoping
        issue(30, 0, 0, 0, 1'b0, 6'h00, "R9 TLB at EL0");
        issue(30, 1, 1, 0, 1'b0, 6'h00, "R9 TLB in 32-bit state");
        issue(14, 1, 0, 0, 1'b1, 6'h18, "R9 address translation at EL1");
        issue(3, 0, 0, 0, 1'b0, 6'h00, "R9 EL1-only cache op at EL0");
        issue(3, 1, 0, 0, 1'b1, 6'h18, "R9 EL1-only cache op at EL1");
        issue(54, 0, 0, 0, 1'b1, 6'h18, "R9 EL0-scope cache op at EL0");

        // R10 nXS forms
        issue(30, 1, 0, 1, 1'b1, 6'h18, "R10 nXS form trapped");
        nxs_trap_ctl = 1'b1;
        issue(30, 1, 0, 1, 1'b0, 6'h00, "R10 nXS form exempt");
        issue(30, 1, 0, 0, 1'b1, 6'h18, "R10 plain form still trapped");
        nxs_trap_ctl = 1'b0;

        // R11 higher-priority exception
        hi_prio_pending = 1'b1;
        issue(53, 1, 0, 0, 1'b0, 6'h00, "R11 suppressed");
        hi_prio_pending = 1'b0;

        // R3 base enables and high levels
        el2_enabled = 1'b0;
        issue(53, 1, 0, 0, 1'b0, 6'h00, "R3 EL2 disabled");
        el2_enabled = 1'b1;
        el3_fgt_en = 1'b0;
        issue(53, 1, 0, 0, 1'b0, 6'h00, "R3 EL3 enable clear");
        el3_present = 1'b0;
        issue(53, 1, 0, 0, 1'b1, 6'h15, "R3 EL3 absent");
        el3_present = 1'b1; el3_fgt_en = 1'b1;
        issue(40, 2, 0, 0, 1'b0, 6'h00, "R3 executing at EL2");
        issue(40, 3, 0, 0, 1'b0, 6'h00, "R3 executing at EL3");

        // R14 reserved class codes
        issue(60, 1, 0, 0, 1'b0, 6'h00, "R14 class 60");
        issue(55, 0, 0, 0, 1'b0, 6'h00, "R14 class 55");

        // R12 idle cycle gives zeros
        issue(53, 1, 0, 0, 1'b1, 6'h15, "R12 trap before idle");
        @(negedge clk);
        check(trap_o === 1'b0 && syndrome_o === 6'd0, "R12",
              $sformatf("idle trap=%0b syn=0x%02h expected 0/0x00", trap_o, syndrome_o));

        // R13 write and instruction in the same cycle use the old value
        write_ctl(64'd0);
        check(rd_data === 64'd0, "R13", $sformatf("rd=0x%016h expected 0", rd_data));
        @(negedge clk);
        wr_en = 1'b1; wr_data = '1;
        insn_class = 6'd53; cur_el = 2'd1; cur_aa32 = 1'b0; insn_nxs = 1'b0;
        insn_valid = 1'b1;
        exp_q.push_back('{1'b0, 6'h00, "R13 same-cycle write uses old value"});
        @(negedge clk);
        wr_en = 1'b0; insn_valid = 1'b0;
        issue(53, 1, 0, 0, 1'b1, 6'h15, "R13 next instruction sees new value");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule